// File: doc/BRIEF.md
# Capture Strobe Delay Calibrator

This block finds a safe sampling instant for an 8-bit parallel converter bus that has no data clock of its own. The capture strobe is delayed by a programmable tap, and the delay line is modelled here only as a tap index. On a start request the block moves the tap from the lowest setting to the highest, one step at a time. After each step it waits a fixed settle time. It then watches the bus for a fixed number of samples.

The converter input is held near midscale, so a correctly captured word is always 0x7F or 0x80. A tap whose window contains only those two codes counts as stable. Any other code marks the tap unstable. When the sweep ends, the block picks the longest unbroken run of stable taps and parks the tap in the middle of that run. This gives the widest timing margin on both sides. The block then pulses done and reports the run length. If no tap is stable, it raises a fail flag instead.

Top module: `strobe_cal`

## Requirements
- R1: During a calibration the tap output starts at 0 and advances by exactly +1 per step up to 2^TAP_W-1 (31 by default), so it visits every setting once.
- R2: A tap is stable only if every judged sample in its window equals 0x7F or 0x80; any other code, including 0x7E and 0x81, makes it unstable.
- R3: For SETTLE_LEN cycles after each tap change (and after start), bus samples are not judged.
- R4: The final tap equals first + floor((length-1)/2), where first and length describe the longest contiguous run of stable taps.
- R5: When two or more runs share the greatest length, the run at the lowest taps is chosen.
- R6: The run length output equals the length of the chosen run, from 1 to 2^TAP_W.
- R7: If no tap is stable, fail is 1, the final tap is 0 and the run length is 0; otherwise fail is 0.
- R8: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle, and the results are valid in that cycle.
- R9: The final tap, run length and fail flag hold their values while idle until the next start.
- R10: After reset the tap is 0, and busy, done, fail and run length are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration sweep (accepted when idle) |
| adc_data | input | 8 | Captured converter word at the current tap |
| tap_sel | output | TAP_W | Capture delay tap index |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No stable tap was found |
| run_len | output | TAP_W+1 | Length of the chosen stable run |

## Verification
Several properties are checked on every cycle:
- the tap only steps upward by one during a sweep;
- done never lasts two cycles;
- a set fail flag always goes with a zero tap and zero length;
- results stay frozen while idle;
- a window can never finish inside its settle time;
- the run tracker's best length stays within range.

Other behaviours can only be shown by the bench's scenarios, which set chosen masks of stable taps:
- that the correct run is chosen;
- that the midpoint is rounded down;
- that ties go to the lower run;
- that near-miss codes are rejected;
- that garbage on the bus during the settle time is ignored.

// File: rtl/strobe_cal_pkg.sv
// Shared types and helpers for the capture strobe calibrator.
// Assumes the converter input is held at midscale during calibration.
package strobe_cal_pkg;
    localparam logic [7:0] MID_LO = 8'h7F;
    localparam logic [7:0] MID_HI = 8'h80;

    typedef enum logic [1:0] {CAL_IDLE, CAL_SWEEP, CAL_FINISH} cal_state_t;
    typedef enum logic [1:0] {WIN_IDLE, WIN_SETTLE, WIN_MEASURE} win_phase_t;

    // True when a captured word is one of the two midscale codes.
    function automatic logic is_mid_code(input logic [7:0] code);
        return (code == MID_LO) || (code == MID_HI);
    endfunction
endpackage

// File: rtl/scal_window.sv
// Per-tap judge. After restart_i it ignores the bus for SETTLE_LEN cycles,
// then samples WIN_LEN words. In the last sample cycle it pulses fin_o,
// with ok_o true when every sample was a midscale code.
// Assumes SETTLE_LEN >= 1 and WIN_LEN >= 1.
module scal_window
    import strobe_cal_pkg::*;
#(
    parameter int SETTLE_LEN = 16,
    parameter int WIN_LEN    = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic [7:0] data_i,
    output logic       fin_o,
    output logic       ok_o
);
    localparam int MAX_LEN = (SETTLE_LEN > WIN_LEN) ? SETTLE_LEN : WIN_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_LEN - 1);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_LEN - 1);

    win_phase_t       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;

    // Step through settle and measure phases, collecting a bad-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= WIN_IDLE;
            cnt_q   <= '0;
            bad_q   <= 1'b0;
        end else if (restart_i) begin
            phase_q <= WIN_SETTLE;
            cnt_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            case (phase_q)
                WIN_SETTLE: begin
                    if (cnt_q == SET_LAST) begin
                        phase_q <= WIN_MEASURE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WIN_MEASURE: begin
                    bad_q <= bad_q | ~is_mid_code(data_i);
                    if (cnt_q == WIN_LAST) begin
                        phase_q <= WIN_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Verdict is presented during the final sample cycle.
    always_comb begin
        fin_o = (phase_q == WIN_MEASURE) && (cnt_q == WIN_LAST);
        ok_o  = ~bad_q & is_mid_code(data_i);
    end

    AST_NO_FIN_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !fin_o); // R3
endmodule

// File: rtl/scal_runfind.sv
// Streaming longest-run tracker. It takes one stable/unstable verdict per
// tap in ascending tap order and keeps the first tap and length of the
// longest run seen. A strictly-greater test keeps ties on the lower run.
// Assumes clr_i comes before the first verdict of a sweep.
module scal_runfind #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic             ok_i,
    input  logic [TAP_W-1:0] idx_i,
    output logic [TAP_W-1:0] best_start_o,
    output logic [TAP_W:0]   best_len_o
);
    localparam int NUM_TAPS = 1 << TAP_W;

    logic [TAP_W-1:0] cur_start_q;
    logic [TAP_W:0]   cur_len_q;
    logic [TAP_W-1:0] best_start_q;
    logic [TAP_W:0]   best_len_q;
    logic [TAP_W:0]   next_len;
    logic [TAP_W-1:0] next_start;

    // Candidate run after absorbing a stable verdict.
    always_comb begin
        next_len   = cur_len_q + 1'b1;
        next_start = (cur_len_q == '0) ? idx_i : cur_start_q;
    end

    // Extend or break the current run and promote it if strictly longer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (vld_i) begin
            if (ok_i) begin
                cur_start_q <= next_start;
                cur_len_q   <= next_len;
                if (next_len > best_len_q) begin
                    best_start_q <= next_start;
                    best_len_q   <= next_len;
                end
            end else begin
                cur_len_q <= '0;
            end
        end
    end

    assign best_start_o = best_start_q;
    assign best_len_o   = best_len_q;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        best_len_q <= (TAP_W+1)'(NUM_TAPS)); // R6
    AST_RUN_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && ok_i && !clr_i && (cur_len_q >= best_len_q))
        |=> (best_len_q == $past(cur_len_q) + 1'b1)); // R4
endmodule

// File: rtl/scal_ctrl.sv
// Sweep sequencer. It starts the sweep at tap 0, steps the tap on each
// window verdict, and after the last tap turns the tracker result into a
// midpoint tap, a run length and a fail flag. It pulses done for one cycle.
// Assumes the window and tracker share its clock and reset.
module scal_ctrl
    import strobe_cal_pkg::*;
#(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fin_i,
    input  logic [TAP_W-1:0] best_start_i,
    input  logic [TAP_W:0]   best_len_i,
    output logic             restart_o,
    output logic             clr_o,
    output logic             vld_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [TAP_W:0]   run_len_o
);
    localparam logic [TAP_W-1:0] TAP_LAST = {TAP_W{1'b1}};

    cal_state_t       state_q;
    logic [TAP_W-1:0] tap_q;
    logic             done_q;
    logic             fail_q;
    logic [TAP_W:0]   run_len_q;
    logic             accept;
    logic             step;
    logic [TAP_W:0]   mid_off;

    // Decode handshake events and the lower-middle offset into the run.
    always_comb begin
        accept    = (state_q == CAL_IDLE) && start_i;
        step      = (state_q == CAL_SWEEP) && fin_i;
        mid_off   = (best_len_i - 1'b1) >> 1;
        restart_o = accept || (step && (tap_q != TAP_LAST));
        clr_o     = accept;
        vld_o     = step;
    end

    // Sequence the sweep and register the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CAL_IDLE;
            tap_q     <= '0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            run_len_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CAL_IDLE: begin
                    if (start_i) begin
                        state_q   <= CAL_SWEEP;
                        tap_q     <= '0;
                        fail_q    <= 1'b0;
                        run_len_q <= '0;
                    end
                end
                CAL_SWEEP: begin
                    if (fin_i) begin
                        if (tap_q == TAP_LAST) begin
                            state_q <= CAL_FINISH;
                        end else begin
                            tap_q <= tap_q + 1'b1;
                        end
                    end
                end
                CAL_FINISH: begin
                    state_q <= CAL_IDLE;
                    done_q  <= 1'b1;
                    if (best_len_i == '0) begin
                        fail_q    <= 1'b1;
                        tap_q     <= '0;
                        run_len_q <= '0;
                    end else begin
                        fail_q    <= 1'b0;
                        tap_q     <= best_start_i + mid_off[TAP_W-1:0];
                        run_len_q <= best_len_i;
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    assign tap_o     = tap_q;
    assign busy_o    = (state_q != CAL_IDLE);
    assign done_o    = done_q;
    assign fail_o    = fail_q;
    assign run_len_o = run_len_q;

    AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_SWEEP)
        |=> (tap_q == $past(tap_q)) || (tap_q == TAP_W'($past(tap_q) + 1'b1))); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> (tap_q == '0) && (run_len_q == '0)); // R7
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (fail_q == (run_len_q == '0))); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CAL_IDLE) && !start_i)
        |=> $stable(tap_q) && $stable(run_len_q) && $stable(fail_q)); // R9
endmodule

// File: rtl/strobe_cal.sv
// Capture strobe delay calibrator top. It wires the sweep sequencer, the
// per-tap window judge and the longest-run tracker together.
// Assumes the converter input sits at midscale while busy is high.
module strobe_cal #(
    parameter int TAP_W      = 5,
    parameter int SETTLE_LEN = 16,
    parameter int WIN_LEN    = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       adc_data,
    output logic [TAP_W-1:0] tap_sel,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [TAP_W:0]   run_len
);
    logic             restart;
    logic             clr;
    logic             vld;
    logic             fin;
    logic             ok;
    logic [TAP_W-1:0] best_start;
    logic [TAP_W:0]   best_len;

    scal_ctrl #(.TAP_W(TAP_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .fin_i        (fin),
        .best_start_i (best_start),
        .best_len_i   (best_len),
        .restart_o    (restart),
        .clr_o        (clr),
        .vld_o        (vld),
        .tap_o        (tap_sel),
        .busy_o       (busy),
        .done_o       (done),
        .fail_o       (fail),
        .run_len_o    (run_len)
    );

    scal_window #(.SETTLE_LEN(SETTLE_LEN), .WIN_LEN(WIN_LEN)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .data_i    (adc_data),
        .fin_o     (fin),
        .ok_o      (ok)
    );

    scal_runfind #(.TAP_W(TAP_W)) u_runfind (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr),
        .vld_i        (vld),
        .ok_i         (ok),
        .idx_i        (tap_sel),
        .best_start_o (best_start),
        .best_len_o   (best_len)
    );
endmodule

// File: tb/sim_strobe_cal.sv
module sim_strobe_cal;
    localparam int TAP_W  = 5;
    localparam int SETTLE = 4;
    localparam int WIN    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       adc_data = 8'h00;
    logic [TAP_W-1:0] tap_sel;
    logic             busy, done, fail;
    logic [TAP_W:0]   run_len;

    int checks = 0;
    int errors = 0;
    logic [31:0] mask = '0;
    int steps_ok = 0;
    int steps_bad = 0;

    strobe_cal #(.TAP_W(TAP_W), .SETTLE_LEN(SETTLE), .WIN_LEN(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_data(adc_data),
        .tap_sel(tap_sel), .busy(busy), .done(done), .fail(fail), .run_len(run_len)
    );

    initial forever #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Garbage during settle; midscale codes on stable taps; near misses elsewhere.
    initial begin
        int since = 0;
        int freec = 0;
        logic [TAP_W-1:0] prev_tap = '0;
        logic prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            freec++;
            if ((busy && !prev_busy) || (tap_sel != prev_tap)) begin
                if (busy && prev_busy) begin
                    if (int'(tap_sel) == int'(prev_tap) + 1) steps_ok++;
                    else steps_bad++;
                end
                since = 0;
            end else begin
                since++;
            end
            prev_tap  = tap_sel;
            prev_busy = busy;
            if (since < SETTLE - 1)            adc_data = 8'h00;
            else if (mask[tap_sel])            adc_data = freec[0] ? 8'h7F : 8'h80;
            else if ((freec % 13) == 0)        adc_data = freec[4] ? 8'h81 : 8'h7E;
            else                               adc_data = 8'h80;
        end
    end

    task automatic expect_of(input logic [31:0] m, output int et, output int el, output int ef);
        int bl = 0, bs = 0, cur = 0, cs = 0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                if (cur == 0) cs = i;
                cur++;
                if (cur > bl) begin bl = cur; bs = cs; end
            end else cur = 0;
        end
        el = bl;
        ef = (bl == 0) ? 1 : 0;
        et = (bl == 0) ? 0 : bs + (bl - 1) / 2;
    endtask

    task automatic run_case(input string tag, input logic [31:0] m);
        int et, el, ef, waited;
        expect_of(m, et, el, ef);
        mask = m;
        steps_ok = 0;
        steps_bad = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 busy after start"}, int'(busy), 1);
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R8 done seen"}, int'(done), 1);
        chk({tag, " R4/R5 tap"}, int'(tap_sel), et);
        chk({tag, " R6 run_len"}, int'(run_len), el);
        chk({tag, " R7 fail"}, int'(fail), ef);
        chk({tag, " R1 tap steps"}, steps_ok, 31);
        chk({tag, " R1 bad steps"}, steps_bad, 0);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, int'(done), 0);
        chk({tag, " R8 busy low"}, int'(busy), 0);
        repeat (6) @(negedge clk);
        chk({tag, " R9 tap held"}, int'(tap_sel), et);
        chk({tag, " R9 len held"}, int'(run_len), el);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 tap", int'(tap_sel), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 fail", int'(fail), 0);
        chk("R10 run_len", int'(run_len), 0);
        // R2 R3: unstable taps carry 0x7E/0x81, all taps see garbage while settling
        run_case("mid run", 32'h001F_FC00);        // taps 10..20
        run_case("R5 tie", 32'h00F0_003C);         // 2..5 and 20..23
        run_case("R7 none", 32'h0000_0000);
        run_case("all", 32'hFFFF_FFFF);
        run_case("top tap", 32'h8000_0000);
        run_case("later longer", 32'hFE00_000F);   // 0..3 and 25..31
        run_case("even run", 32'h0000_3F00);       // 8..13
        run_case("R2 alternate", 32'h5555_5555);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule